// File: doc/BRIEF.md
# Banked MSI and INTx Interrupt Aggregator

This block gathers 32 message-signaled interrupt vectors and 4 level legacy INTx lines and exposes them to software through banked pending and mask registers. An inbound message, delivered either on a dedicated message port or as a register write to the doorbell, carries a vector number. The block records that vector as pending in one of 8 MSI banks. The vectors are interleaved across the banks: vector v goes to bank v mod 8 at bit v div 8, so bank 0 collects vectors 0, 8, 16 and 24.

Each MSI bank and each INTx line drives its own registered interrupt output. The output is high while that bank holds a bit that is both pending and enabled. Software clears pending bits by writing ones to them. It enables bits through one register that sets them and another that clears them. When software writes a bank code to the end-of-interrupt register, the matching output drops for one cycle, and it comes back if work is still pending.

Top module: `msi_intx_aggr`

## Requirements
- R1: After reset, every pending bit and every enable bit reads 0, and every bit of `msi_irq` and `intx_irq` is 0.
- R2: A doorbell with vector v in 0..31 sets bank v mod 8, bit v>>3. The doorbell is either a register write of v to offset 0x054 or a `msg_valid` cycle with `msg_vector` = v. Bank k's pending bits are read in bits 3:0 at offset 0x104+16k.
- R3: A doorbell whose value is 32 or more changes no pending bit.
- R4: Writing a mask to offset 0x108+16k sets those enable bits of MSI bank k. Writing a mask to 0x10C+16k clears them. Other enable bits are kept. Reading either offset returns the bank's enable bits in bits 3:0.
- R5: Writing a mask to offset 0x104+16k clears exactly the pending bits of bank k that are 1 in the mask.
- R6: `msi_irq[k]` is high in the cycle after one in which bank k has a bit that is both pending and enabled, and low otherwise.
- R7: Writing k+4 (k in 0..7) to offset 0x050 holds `msi_irq[k]` low in the following cycle. The output then reasserts if bits are still pending and enabled. Other outputs are unaffected.
- R8: While `intx_in[i]` is high, pending bit 0 at offset 0x184+16i is set and stays set until cleared by writing 1 to it. Enable bit 0 is set through 0x188+16i and cleared through 0x18C+16i. `intx_irq[i]` follows the rules of R6, and writing i to 0x050 is its end-of-interrupt, following R7.
- R9: When a message doorbell and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends set.
- R10: An end-of-interrupt write with a value of 12 or more affects no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| msg_valid | input | 1 | Inbound message doorbell strobe |
| msg_vector | input | 32 | Vector number carried by the message |
| intx_in | input | 4 | Legacy interrupt line levels |
| msi_irq | output | 8 | Per-MSI-bank interrupt outputs |
| intx_irq | output | 4 | Per-INTx-line interrupt outputs |

## Verification
The hardest situation to reach is a collision: a message doorbell and a software clear hit the same pending bit in the very same cycle. A second, harder one is an end-of-interrupt while work is still pending, which must show a one-cycle dip in the output. Random traffic alone rarely lines these up. The bench therefore drives the message port and the register port in the same cycle on a bit it has set beforehand. It also issues end-of-interrupt writes to banks it has left pending and enabled, and samples the output in each of the two cycles that follow. Random mixes of doorbells (including out-of-range vectors), clears, mask updates and end-of-interrupt codes are checked against a bench model after every operation.

// File: rtl/msi_intx_aggr_pkg.sv
`timescale 1ns/1ps
package msi_intx_aggr_pkg;
    localparam int unsigned OFF_EOI       = 'h050;
    localparam int unsigned OFF_DOORBELL  = 'h054;
    localparam int unsigned OFF_MSI_BASE  = 'h100;
    localparam int unsigned OFF_INTX_BASE = 'h180;
    localparam int unsigned BANK_STRIDE   = 16;
    localparam int unsigned SUB_PENDING   = 4;
    localparam int unsigned SUB_EN_SET    = 8;
    localparam int unsigned SUB_EN_CLR    = 12;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_PENDING,
        ACC_EN_SET,
        ACC_EN_CLR
    } acc_e;
endpackage

// File: rtl/msi_intx_aggr_vecmap.sv
`timescale 1ns/1ps
// Turns a doorbell vector number into a one-hot pending-set pattern,
// laid out bank-major: bit (bank*W + slot).
module msi_intx_aggr_vecmap #(
    parameter int NB = 8,
    parameter int W  = 4,
    parameter int DW = 32
) (
    input  logic              valid,
    input  logic [DW-1:0]     vector,
    output logic [NB*W-1:0]   set_vec
);
    localparam int NV = NB * W;

    always_comb begin
        set_vec = '0;
        for (int v = 0; v < NV; v++) begin
            if (valid && (vector == DW'(v))) begin
                set_vec[(v % NB) * W + (v / NB)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msi_intx_aggr_bank.sv
`timescale 1ns/1ps
// One bank: pending bits with hardware set / software clear, an enable
// mask with separate set and clear strobes, and a registered output.
module msi_intx_aggr_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] sw_clr,
    input  logic [W-1:0] en_set,
    input  logic [W-1:0] en_clr,
    input  logic         eoi,
    output logic [W-1:0] pending,
    output logic [W-1:0] enable,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] en;
        logic         irq;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        // hardware set is applied after the clear, so it wins a collision
        bank_d.pend = (bank_q.pend & ~sw_clr) | hw_set;
        bank_d.en   = (bank_q.en | en_set) & ~en_clr;
        bank_d.irq  = (|(bank_q.pend & bank_q.en)) && !eoi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pending = bank_q.pend;
    assign enable  = bank_q.en;
    assign irq     = bank_q.irq;
endmodule

// File: rtl/msi_intx_aggr_regdec.sv
`timescale 1ns/1ps
// Address decode for writes into per-bank strobes, and the read mux.
module msi_intx_aggr_regdec
    import msi_intx_aggr_pkg::*;
#(
    parameter int NB = 8,
    parameter int W  = 4,
    parameter int NI = 4,
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [NB*W-1:0]  msi_pend,
    input  logic [NB*W-1:0]  msi_en,
    input  logic [NI-1:0]    intx_pend,
    input  logic [NI-1:0]    intx_en,
    output logic             db_wr,
    output logic [NB*W-1:0]  msi_clr,
    output logic [NB*W-1:0]  msi_en_set,
    output logic [NB*W-1:0]  msi_en_clr,
    output logic [NB-1:0]    msi_eoi,
    output logic [NI-1:0]    intx_clr,
    output logic [NI-1:0]    intx_en_set,
    output logic [NI-1:0]    intx_en_clr,
    output logic [NI-1:0]    intx_eoi,
    output logic [DW-1:0]    rdata
);
    acc_e msi_acc  [NB];
    acc_e intx_acc [NI];

    function automatic acc_e classify(input logic [AW-1:0] a, input int unsigned base);
        acc_e r = ACC_NONE;
        if (a == AW'(base + SUB_PENDING)) r = ACC_PENDING;
        if (a == AW'(base + SUB_EN_SET))  r = ACC_EN_SET;
        if (a == AW'(base + SUB_EN_CLR))  r = ACC_EN_CLR;
        return r;
    endfunction

    always_comb begin
        for (int k = 0; k < NB; k++) begin
            msi_acc[k] = classify(addr, OFF_MSI_BASE + BANK_STRIDE * k);
        end
        for (int i = 0; i < NI; i++) begin
            intx_acc[i] = classify(addr, OFF_INTX_BASE + BANK_STRIDE * i);
        end
    end

    always_comb begin
        db_wr       = wr && (addr == AW'(OFF_DOORBELL));
        msi_clr     = '0;
        msi_en_set  = '0;
        msi_en_clr  = '0;
        msi_eoi     = '0;
        intx_clr    = '0;
        intx_en_set = '0;
        intx_en_clr = '0;
        intx_eoi    = '0;
        rdata       = '0;
        for (int k = 0; k < NB; k++) begin
            if (wr && msi_acc[k] == ACC_PENDING) msi_clr[k*W +: W]    = wdata[W-1:0];
            if (wr && msi_acc[k] == ACC_EN_SET)  msi_en_set[k*W +: W] = wdata[W-1:0];
            if (wr && msi_acc[k] == ACC_EN_CLR)  msi_en_clr[k*W +: W] = wdata[W-1:0];
            if (wr && addr == AW'(OFF_EOI) && wdata == DW'(k + NI)) msi_eoi[k] = 1'b1;
            if (msi_acc[k] == ACC_PENDING) rdata[W-1:0] = msi_pend[k*W +: W];
            if (msi_acc[k] == ACC_EN_SET || msi_acc[k] == ACC_EN_CLR) rdata[W-1:0] = msi_en[k*W +: W];
        end
        for (int i = 0; i < NI; i++) begin
            if (wr && intx_acc[i] == ACC_PENDING) intx_clr[i]    = wdata[0];
            if (wr && intx_acc[i] == ACC_EN_SET)  intx_en_set[i] = wdata[0];
            if (wr && intx_acc[i] == ACC_EN_CLR)  intx_en_clr[i] = wdata[0];
            if (wr && addr == AW'(OFF_EOI) && wdata == DW'(i)) intx_eoi[i] = 1'b1;
            if (intx_acc[i] == ACC_PENDING) rdata[0] = intx_pend[i];
            if (intx_acc[i] == ACC_EN_SET || intx_acc[i] == ACC_EN_CLR) rdata[0] = intx_en[i];
        end
    end
endmodule

// File: rtl/msi_intx_aggr.sv
`timescale 1ns/1ps
module msi_intx_aggr #(
    parameter int NUM_VEC      = 32,
    parameter int NUM_MSI_BANK = 8,
    parameter int NUM_INTX     = 4,
    parameter int AW           = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [AW-1:0]           reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic                    msg_valid,
    input  logic [31:0]             msg_vector,
    input  logic [NUM_INTX-1:0]     intx_in,
    output logic [NUM_MSI_BANK-1:0] msi_irq,
    output logic [NUM_INTX-1:0]     intx_irq
);
    localparam int NB = NUM_MSI_BANK;
    localparam int NI = NUM_INTX;
    localparam int W  = NUM_VEC / NUM_MSI_BANK;
    localparam int DW = 32;

    logic            db_wr;
    logic [NB*W-1:0] set_reg, set_msg, msi_set;
    logic [NB*W-1:0] msi_pend, msi_en, msi_clr, msi_en_set, msi_en_clr;
    logic [NB-1:0]   msi_eoi;
    logic [NI-1:0]   intx_pend, intx_en, intx_clr, intx_en_set, intx_en_clr, intx_eoi;

    msi_intx_aggr_regdec #(.NB(NB), .W(W), .NI(NI), .AW(AW), .DW(DW)) u_dec (
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .msi_pend(msi_pend), .msi_en(msi_en),
        .intx_pend(intx_pend), .intx_en(intx_en),
        .db_wr(db_wr), .msi_clr(msi_clr), .msi_en_set(msi_en_set),
        .msi_en_clr(msi_en_clr), .msi_eoi(msi_eoi),
        .intx_clr(intx_clr), .intx_en_set(intx_en_set),
        .intx_en_clr(intx_en_clr), .intx_eoi(intx_eoi),
        .rdata(reg_rdata)
    );

    msi_intx_aggr_vecmap #(.NB(NB), .W(W), .DW(DW)) u_map_reg (
        .valid(db_wr), .vector(reg_wdata), .set_vec(set_reg)
    );

    msi_intx_aggr_vecmap #(.NB(NB), .W(W), .DW(DW)) u_map_msg (
        .valid(msg_valid), .vector(msg_vector), .set_vec(set_msg)
    );

    assign msi_set = set_reg | set_msg;

    for (genvar k = 0; k < NB; k++) begin : g_msi
        msi_intx_aggr_bank #(.W(W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .hw_set(msi_set[k*W +: W]), .sw_clr(msi_clr[k*W +: W]),
            .en_set(msi_en_set[k*W +: W]), .en_clr(msi_en_clr[k*W +: W]),
            .eoi(msi_eoi[k]),
            .pending(msi_pend[k*W +: W]), .enable(msi_en[k*W +: W]),
            .irq(msi_irq[k])
        );
    end

    for (genvar i = 0; i < NI; i++) begin : g_intx
        msi_intx_aggr_bank #(.W(1)) u_line (
            .clk(clk), .rst_n(rst_n),
            .hw_set(intx_in[i]), .sw_clr(intx_clr[i]),
            .en_set(intx_en_set[i]), .en_clr(intx_en_clr[i]),
            .eoi(intx_eoi[i]),
            .pending(intx_pend[i]), .enable(intx_en[i]),
            .irq(intx_irq[i])
        );
    end
endmodule

// File: rtl/msi_intx_aggr_chk.sv
`timescale 1ns/1ps
module msi_intx_aggr_chk #(
    parameter int NB = 8,
    parameter int W  = 4,
    parameter int NI = 4,
    parameter int AW = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [31:0]     reg_wdata,
    input logic            msg_valid,
    input logic [31:0]     msg_vector,
    input logic [NI-1:0]   intx_in,
    input logic [NB-1:0]   msi_irq,
    input logic [NI-1:0]   intx_irq,
    input logic [NB*W-1:0] msi_pend,
    input logic [NB*W-1:0] msi_en,
    input logic [NI-1:0]   intx_pend
);
    localparam int NV = NB * W;

    for (genvar k = 0; k < NB; k++) begin : g_bank
        // R7: end-of-interrupt for bank k drops its output next cycle
        a_r7_eoi_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == AW'('h050) && reg_wdata == 32'(k + NI)) |=> !msi_irq[k]);
        // R6: output only after a cycle with pending and enabled work
        a_r6_irq_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
            msi_irq[k] |-> $past(|(msi_pend[k*W +: W] & msi_en[k*W +: W])));
    end

    for (genvar v = 0; v < NV; v++) begin : g_vec
        // R2 and R9: message doorbell leaves its bit set, even against a clear
        a_r2_msg_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_valid && msg_vector == 32'(v)) |=> msi_pend[(v % NB) * W + (v / NB)]);
    end

    // R3: out-of-range message vector changes nothing
    a_r3_big_vector_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_vector >= 32'(NV) && !reg_wr) |=> $stable(msi_pend));

    for (genvar i = 0; i < NI; i++) begin : g_intx
        // R8: a high line is latched as pending
        a_r8_intx_latch: assert property (@(posedge clk) disable iff (!rst_n)
            intx_in[i] |=> intx_pend[i]);
        // R8: INTx end-of-interrupt drops that line's output
        a_r8_intx_eoi_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == AW'('h050) && reg_wdata == 32'(i)) |=> !intx_irq[i]);
    end
endmodule

bind msi_intx_aggr msi_intx_aggr_chk #(.NB(NB), .W(W), .NI(NI), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .intx_in(intx_in), .msi_irq(msi_irq), .intx_irq(intx_irq),
    .msi_pend(msi_pend), .msi_en(msi_en), .intx_pend(intx_pend)
);

// File: tb/msi_intx_aggr_tb.sv
`timescale 1ns/1ps
module msi_intx_aggr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid = 1'b0;
    logic [31:0] msg_vector = '0;
    logic [3:0]  intx_in = '0;
    logic [7:0]  msi_irq;
    logic [3:0]  intx_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [3:0] m_pend [8];
    logic [3:0] m_en   [8];
    logic [3:0] x_pend;
    logic [3:0] x_en;

    always #10 clk = ~clk;

    msi_intx_aggr u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_vector(msg_vector), .intx_in(intx_in), .msi_irq(msi_irq),
        .intx_irq(intx_irq)
    );

    function automatic logic [7:0] exp_msi_irq();
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = |(m_pend[k] & m_en[k]);
        return r;
    endfunction

    function automatic logic [11:0] msi_off(input int k, input int sub);
        return 12'(32'h100 + 16 * k + sub);
    endfunction

    function automatic logic [11:0] intx_off(input int i, input int sub);
        return 12'(32'h180 + 16 * i + sub);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic msg(input logic [31:0] v);
        @(negedge clk);
        msg_valid = 1'b1; msg_vector = v;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic model_db(input logic [31:0] v);
        if (v < 32) m_pend[v % 8][v / 8] = 1'b1;
    endtask

    task automatic idle_and_compare(input string req);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rd_chk({req, " pending"}, msi_off(k, 4), {28'd0, m_pend[k]});
            rd_chk({req, " enable"}, msi_off(k, 8), {28'd0, m_en[k]});
        end
        check({req, " R6 msi_irq"}, {24'd0, msi_irq}, {24'd0, exp_msi_irq()});
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        logic [3:0]  mask;
        int          k, op;
        void'($urandom(32'd20240611));
        for (int j = 0; j < 8; j++) begin m_pend[j] = '0; m_en[j] = '0; end
        x_pend = '0; x_en = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int j = 0; j < 8; j++) begin
            rd_chk("R1 pending", msi_off(j, 4), 32'd0);
            rd_chk("R1 enable", msi_off(j, 8), 32'd0);
        end
        check("R1 msi_irq", {24'd0, msi_irq}, 32'd0);
        check("R1 intx_irq", {28'd0, intx_irq}, 32'd0);

        // R2: directed doorbells at bank boundaries
        wr(12'h054, 32'd0);   model_db(0);
        msg(32'd31);          model_db(31);
        wr(12'h054, 32'd9);   model_db(9);
        idle_and_compare("R2 doorbell");
        rd_chk("R2 bank7 vector31", msi_off(7, 4), 32'h8);
        rd_chk("R2 bank1 vector9", msi_off(1, 4), 32'h2);

        // R3: out-of-range vectors
        wr(12'h054, 32'd32);
        msg(32'hFFFF_FFFF);
        idle_and_compare("R3 ignored");

        // R4 and R6: enable and output timing
        wr(msi_off(7, 8), 32'hC);   m_en[7] = 4'hC;
        check("R6 one cycle latency", {31'd0, msi_irq[7]}, 32'd0);
        @(negedge clk);
        check("R6 asserted", {31'd0, msi_irq[7]}, 32'd1);
        wr(msi_off(7, 12), 32'h4);  m_en[7] = 4'h8;
        idle_and_compare("R4 clear keeps others");

        // R7: EOI with work pending dips one cycle then reasserts
        wr(12'h050, 32'd11);
        check("R7 eoi dip", {24'd0, msi_irq}, {24'd0, exp_msi_irq() & 8'h7F});
        @(negedge clk);
        check("R7 reassert", {31'd0, msi_irq[7]}, 32'd1);

        // R9: collision of message doorbell and clear on vector 11
        msg(32'd11); model_db(11);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = msi_off(3, 4); reg_wdata = 32'h2;
        msg_valid = 1'b1; msg_vector = 32'd11;
        @(negedge clk);
        reg_wr = 1'b0; msg_valid = 1'b0;
        rd_chk("R9 set wins", msi_off(3, 4), 32'h2);

        // R5: clear of one bit only
        wr(msi_off(3, 4), 32'h2);  m_pend[3][1] = 1'b0;
        idle_and_compare("R5 w1c");

        // R8: INTx line 2
        @(negedge clk); intx_in[2] = 1'b1;
        @(negedge clk); intx_in[2] = 1'b0;
        rd_chk("R8 latched", intx_off(2, 4), 32'd1);
        wr(intx_off(2, 8), 32'd1);
        @(negedge clk);
        check("R8 intx_irq", {28'd0, intx_irq}, 32'h4);
        wr(12'h050, 32'd2);
        check("R8 intx eoi dip", {28'd0, intx_irq}, 32'h0);
        @(negedge clk);
        check("R8 intx reassert", {28'd0, intx_irq}, 32'h4);
        wr(intx_off(2, 4), 32'd1);
        @(negedge clk);
        rd_chk("R8 cleared", intx_off(2, 4), 32'd0);
        check("R8 intx low", {28'd0, intx_irq}, 32'h0);
        rd_chk("R8 enable kept", intx_off(2, 12), 32'd1);
        wr(intx_off(2, 12), 32'd1);
        rd_chk("R8 enable cleared", intx_off(2, 8), 32'd0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            op   = int'($urandom % 6);
            k    = int'($urandom % 8);
            mask = 4'($urandom);
            case (op)
                0: begin v = $urandom % 40; wr(12'h054, v); model_db(v); end
                1: begin v = $urandom % 40; msg(v); model_db(v); end
                2: begin wr(msi_off(k, 4), {28'd0, mask}); m_pend[k] &= ~mask; end
                3: begin wr(msi_off(k, 8), {28'd0, mask}); m_en[k] |= mask; end
                4: begin wr(msi_off(k, 12), {28'd0, mask}); m_en[k] &= ~mask; end
                default: begin
                    v = $urandom % 16;
                    wr(12'h050, v);
                    if (v >= 4 && v < 12)
                        check("R7 random eoi", {24'd0, msi_irq},
                              {24'd0, exp_msi_irq() & ~(8'd1 << (v - 4))});
                    else
                        check("R10 eoi ignored", {24'd0, msi_irq}, {24'd0, exp_msi_irq()});
                end
            endcase
            idle_and_compare("R2-R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule